// File: doc/BRIEF.md
# LFSR Stochastic Bitstream Encoder

This block turns a 16-bit probability threshold into a unipolar stochastic bitstream for stochastic-computing datapaths. A 16-bit Galois shift register produces a maximal-length pseudo-random sequence. On every clock where the stream is running and `enable` is high, the current register value is compared against the threshold. The comparison yields one stream bit, and the register then takes one step. A bit is 1 when the register is strictly below the threshold, so the ones-density of the stream approaches threshold/65535.

Bits are packed least-significant first into 32-bit words. Each finished word is presented for one cycle with `word_valid`. The caller asks for a stream length in bits when it pulses `start`. A last word that is only partly filled has zeros in its unused high bits. One cycle after the final word, `done` pulses.

The register keeps its value from one stream to the next. It can be reloaded while the block is idle, so two runs that start from the same seed give the same words. The controller has four states:
- IDLE waits for `start`.
- RUN produces bits.
- DRAIN covers the cycle in which the last word is on the output.
- FINISH raises `done`.

The state transitions are:
- IDLE→RUN on `start` with a non-zero length.
- IDLE→FINISH on `start` with a zero length.
- RUN→DRAIN on the enabled cycle that consumes the final bit.
- DRAIN→FINISH unconditionally.
- FINISH→IDLE unconditionally.

Top module: `sc_lfsr_encoder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the register holds 0xACE1, and `word_valid`, `done` and `busy` are 0.
- R2: Each generated bit is 1 exactly when the register value is strictly less than the threshold captured at `start`. The register then steps: it shifts right by one, and when the bit shifted out was 1 it is XORed with 0xD008. The register is never zero.
- R3: Stream bit n is placed at bit position (n mod 32) of word floor(n/32).
- R4: A stream of L bits produces exactly ceil(L/32) `word_valid` pulses. Each pulse comes in the cycle after the edge that consumed the word's last bit.
- R5: Unused high bits of a final partial word are 0.
- R6: While `enable` is low, no bit is generated and the register does not move. The stream then continues exactly where it paused.
- R7: `done` is high for exactly one cycle, in the cycle after the final `word_valid`. A zero-length request gives no words and raises `done` in the cycle after the start edge.
- R8: `seed_load` in IDLE replaces the register with `seed_value`, and a seed of 0 is stored as 0x0001. `seed_load` is ignored while `busy` is high.
- R9: Two streams started from the same seed, threshold and length produce identical word sequences.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_value` into the register (idle only) |
| seed_value | input | 16 | Seed to load |
| start | input | 1 | Begin a stream (idle only) |
| stream_len | input | LEN_W (16) | Number of bits requested, captured at `start` |
| threshold | input | 16 | Probability threshold, captured at `start` |
| enable | input | 1 | Generate one bit this cycle while running |
| word_data | output | 32 | Packed output word |
| word_valid | output | 1 | `word_data` holds a finished word this cycle |
| done | output | 1 | One-cycle pulse after the final word |
| busy | output | 1 | Controller is not in IDLE |

## Verification
The bound checker watches every cycle for the following:
- The register never reaches zero.
- The register holds still whenever `enable` and `seed_load` are both low.
- Words are only strobed while busy.
- `done` is a lone pulse that never coincides with a word.
- Nothing is strobed when idle.

Other properties are shown only by the bench scenarios, which compare each word against a behavioural model:
- The exact word values and bit ordering.
- The zero padding of the last word.
- The number of words per stream.
- The one-cycle gap between the last word and `done`.
- The zero-seed substitution.
- The repeatability from equal seeds.

// File: rtl/sc_enc_pkg.sv
package sc_enc_pkg;

    localparam int unsigned RNG_W = 16;
    localparam logic [RNG_W-1:0] GALOIS_TAPS  = 16'hD008;
    localparam logic [RNG_W-1:0] DEFAULT_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } enc_state_t;

endpackage

// File: rtl/sc_lfsr_core.sv
module sc_lfsr_core #(
    parameter int unsigned        W          = 16,
    parameter logic [W-1:0]       TAPS       = 16'hD008,
    parameter logic [W-1:0]       RESET_SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_value,
    input  logic         advance,
    output logic [W-1:0] state_o
);

    localparam logic [W-1:0] SAFE_SEED = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] state_q;
    logic [W-1:0] step_val;
    logic [W-1:0] seed_fixed;

    // Galois step: right shift, fold taps in when the exiting bit is set
    genvar gi;
    generate
        for (gi = 0; gi < int'(W); gi++) begin : g_step
            if (gi == int'(W) - 1) begin : g_top
                assign step_val[gi] = TAPS[gi] & state_q[0];
            end else begin : g_low
                assign step_val[gi] = state_q[gi+1] ^ (TAPS[gi] & state_q[0]);
            end
        end
    endgenerate

    assign seed_fixed = (load_value == '0) ? SAFE_SEED : load_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_SEED;
        end else if (load) begin
            state_q <= seed_fixed;
        end else if (advance) begin
            state_q <= step_val;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/sc_bit_packer.sv
module sc_bit_packer #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned POS_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              flush,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;

    genvar gb;
    generate
        for (gb = 0; gb < int'(WORD_W); gb++) begin : g_lane
            assign acc_next[gb] = acc_q[gb] |
                (bit_en & bit_in & (bit_pos == POS_W'(gb)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clear) begin
                acc_q <= '0;
            end else if (flush) begin
                word_o  <= acc_next;
                valid_o <= 1'b1;
                acc_q   <= '0;
            end else begin
                acc_q <= acc_next;
            end
        end
    end

endmodule

// File: rtl/sc_enc_ctrl.sv
module sc_enc_ctrl
    import sc_enc_pkg::*;
#(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned POS_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] stream_len,
    input  logic             enable,
    output enc_state_t       state_o,
    output logic             accept_o,
    output logic             advance_o,
    output logic             flush_o,
    output logic [POS_W-1:0] bit_pos_o
);

    enc_state_t       state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             last_bit;
    logic             word_end;

    assign last_bit = (cnt_q == len_q - LEN_W'(1));
    assign word_end = &cnt_q[POS_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (stream_len == '0) ? ST_FINISH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (enable && last_bit) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o  = 1'b0;
        advance_o = 1'b0;
        flush_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start;
            ST_RUN: begin
                advance_o = enable;
                flush_o   = enable & (word_end | last_bit);
            end
            ST_DRAIN, ST_FINISH: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (accept_o) begin
            cnt_q <= '0;
            len_q <= stream_len;
        end else if (advance_o) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign state_o   = state_q;
    assign bit_pos_o = cnt_q[POS_W-1:0];

endmodule

// File: rtl/sc_lfsr_encoder.sv
module sc_lfsr_encoder
    import sc_enc_pkg::*;
#(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned POS_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [RNG_W-1:0]  seed_value,
    input  logic              start,
    input  logic [LEN_W-1:0]  stream_len,
    input  logic [RNG_W-1:0]  threshold,
    input  logic              enable,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              done,
    output logic              busy
);

    enc_state_t       state;
    logic             accept;
    logic             advance;
    logic             flush;
    logic [POS_W-1:0] bit_pos;
    logic [RNG_W-1:0] lfsr_q;
    logic [RNG_W-1:0] thr_q;
    logic             seed_ok;
    logic             stream_bit;

    sc_enc_ctrl #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .stream_len (stream_len),
        .enable     (enable),
        .state_o    (state),
        .accept_o   (accept),
        .advance_o  (advance),
        .flush_o    (flush),
        .bit_pos_o  (bit_pos)
    );

    assign seed_ok = seed_load & (state == ST_IDLE);

    sc_lfsr_core #(.W(RNG_W), .TAPS(GALOIS_TAPS), .RESET_SEED(DEFAULT_SEED)) u_rng (
        .clk        (clk),
        .rst        (rst),
        .load       (seed_ok),
        .load_value (seed_value),
        .advance    (advance),
        .state_o    (lfsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (accept) begin
            thr_q <= threshold;
        end
    end

    assign stream_bit = (lfsr_q < thr_q);

    sc_bit_packer #(.WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .bit_en  (advance),
        .bit_in  (stream_bit),
        .bit_pos (bit_pos),
        .flush   (flush),
        .word_o  (word_data),
        .valid_o (word_valid)
    );

    assign done = (state == ST_FINISH);
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sc_lfsr_encoder_chk.sv
module sc_lfsr_encoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        seed_load,
    input logic        word_valid,
    input logic        done,
    input logic        busy,
    input logic [15:0] lfsr_q
);

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != 16'h0000); // R2

    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!enable && !seed_load) |=> $stable(lfsr_q)); // R6

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> busy); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_APART_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        done |-> !word_valid); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!word_valid && !done)); // R1

endmodule

bind sc_lfsr_encoder sc_lfsr_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .seed_load  (seed_load),
    .word_valid (word_valid),
    .done       (done),
    .busy       (busy),
    .lfsr_q     (lfsr_q)
);

// File: tb/tb_sc_lfsr_encoder.sv
`timescale 1ns/1ps
module tb_sc_lfsr_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = '0;
    logic        start = 1'b0;
    logic [15:0] stream_len = '0;
    logic [15:0] threshold = '0;
    logic        enable = 1'b0;
    logic [31:0] word_data;
    logic        word_valid;
    logic        done;
    logic        busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] m_lfsr;            // model register
    logic [31:0] expq[$];
    logic [31:0] capt[$];
    logic [31:0] first_run[$];

    always #2 clk = ~clk;           // 250 MHz

    sc_lfsr_encoder dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .start(start), .stream_len(stream_len), .threshold(threshold),
        .enable(enable), .word_data(word_data), .word_valid(word_valid),
        .done(done), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_next(input logic [15:0] s);
        logic [15:0] n;
        n = {1'b0, s[15:1]};
        if (s[0]) n = n ^ 16'hD008;
        return n;
    endfunction

    // Behavioural expectation of the words of one stream
    task automatic model_stream(input int len, input logic [15:0] thr);
        logic [31:0] w;
        w = '0;
        expq.delete();
        for (int n = 0; n < len; n++) begin
            if (m_lfsr < thr) w[n % 32] = 1'b1;
            m_lfsr = m_next(m_lfsr);
            if ((n % 32) == 31 || n == len - 1) begin
                expq.push_back(w);
                w = '0;
            end
        end
    endtask

    // mode 0: enable always; 1: enable gaps; 2: also pokes seed_load/start while busy
    task automatic run_stream(input int len, input logic [15:0] thr, input int mode, input string tag);
        int  nwords, cyc;
        bit  prev_valid, seen_done;
        model_stream(len, thr);
        nwords = expq.size();
        capt.delete();
        @(negedge clk);
        start = 1'b1; stream_len = 16'(len); threshold = thr; enable = 1'b1;
        @(negedge clk);
        start = 1'b0;
        threshold = ~thr;               // must not matter after capture
        prev_valid = 1'b0; seen_done = 1'b0; cyc = 0;
        while (!seen_done && cyc < 5000) begin
            if (word_valid) begin
                capt.push_back(word_data);
                if (expq.size() == 0) begin
                    chk({tag, " R4 extra word"}, 32'd1, 32'd0);
                end else begin
                    chk({tag, " R2 R3 R5 word"}, word_data, expq.pop_front());
                end
            end
            if (done) begin
                seen_done = 1'b1;
                chk({tag, " R7 done after last word"}, {31'd0, prev_valid}, {31'd0, len > 0});
                chk({tag, " R4 word count"}, capt.size(), nwords);
            end
            prev_valid = word_valid;
            enable = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            seed_load = (mode == 2) && (cyc == 5);   // R8 ignored while busy
            seed_value = 16'h1234;
            start = (mode == 2) && (cyc == 7);        // R10 ignored while busy
            stream_len = 16'd1;
            cyc++;
            @(negedge clk);
        end
        seed_load = 1'b0; start = 1'b0; enable = 1'b0;
        if (!seen_done) chk({tag, " R7 done never seen"}, 32'd0, 32'd1);
        chk({tag, " R7 done single"}, {31'd0, done}, 32'd0);
        @(negedge clk);
        chk({tag, " R10 idle after stream"}, {31'd0, busy}, 32'd0);
        chk({tag, " R4 no stray word"}, {31'd0, word_valid}, 32'd0);
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(negedge clk);
        seed_load = 1'b1; seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        m_lfsr = (s == 16'h0) ? 16'h0001 : s;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_lfsr = 16'hACE1;
        chk("R1 word_valid after reset", {31'd0, word_valid}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);

        run_stream(64, 16'h8000, 0, "R1 default seed");
        run_stream(70, 16'h4000, 0, "R3 R5 partial");
        run_stream(45, 16'h0000, 0, "R2 threshold zero");
        run_stream(100, 16'hFFFF, 0, "R2 threshold max");
        run_stream(96, 16'h9000, 1, "R6 enable gaps");
        run_stream(33, 16'h6000, 2, "R8 R10 busy pokes");
        run_stream(1, 16'hFFFF, 0, "R4 single bit");
        run_stream(0, 16'h8000, 0, "R7 zero length");

        load_seed(16'h0000);
        run_stream(40, 16'h0002, 0, "R8 zero seed");

        load_seed(16'h5A5A);
        run_stream(80, 16'h7777, 1, "R9 first");
        first_run = capt;
        load_seed(16'h5A5A);
        run_stream(80, 16'h7777, 0, "R9 second");
        chk("R9 run lengths equal", capt.size(), first_run.size());
        for (int i = 0; i < capt.size() && i < first_run.size(); i++)
            chk("R9 identical words", capt[i], first_run[i]);

        run_stream(1000, 16'h2000, 1, "R2 long stream");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_lfsr = 16'hACE1;
        run_stream(32, 16'h8000, 0, "R1 after second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule